// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is a register-mapped engine that runs single-bit SPI transactions against a NOR flash. Software loads a few byte registers and sets a trigger bit in the command register. The engine then builds the serial frame, runs it with chip select held low, and clears the trigger bit once the last bit has been sent. Software learns that a transfer is finished by polling the trigger bits until they read zero.

Four operations are supported:
- a raw frame of up to six bytes, with a software-set bit count;
- a status fetch;
- a one-byte read at a 24-bit address;
- a one-byte program at that address.

The read and program operations can advance the address after they finish. The program operation always sends a write-enable frame before the program frame.

A key register acts as a lock. Until the key value has been written, every trigger is refused. The serial clock runs in mode 0 at half the system clock.

Top module: `nor_cmd_engine`

Register offsets on `addr_i`:

| Offset | Register | Notes |
|---|---|---|
| 0x00 | command | bit0 raw, bit1 status, bit2 read, bit3 program, bit7 auto-advance |
| 0x01 | bit count | |
| 0x02 | key | reads back 1 in bit 0 when unlocked |
| 0x03 | status byte | |
| 0x04 | address bits 23:16 | |
| 0x05 | address bits 15:8 | |
| 0x06 | address bits 7:0 | |
| 0x07 | read byte | |
| 0x08 | program byte | |
| 0x10+i | raw byte i | i = 0..5 |

## Requirements
- R1: After reset the command register reads 0x00, the key register reads 0x00 (locked), chip select is high and the serial clock is low.
- R2: While the key register does not hold 0x30, a write to the command register starts no frame and leaves its trigger bits at zero.
- R3: A raw command sends the raw bytes MSB first, starting with byte 5 and moving down toward byte 0, for exactly the programmed bit count. A count above 48 sends 48 bits. A count of 0 completes without moving chip select.
- R4: A trigger bit reads 1 from the write that starts it until its transfer ends, then reads 0. Bit 7 (auto-advance) keeps the value last written.
- R5: The status trigger sends opcode 0x05 and places the next 8 bits received on MISO into the status register, in a 16-bit frame.
- R6: The read trigger sends opcode 0x03 and the 24-bit address MSB first, then stores the next 8 received bits in the read-byte register, in a 40-bit frame. With auto-advance set, the address then increases by one.
- R7: The program trigger sends a separate 8-bit frame with opcode 0x06. It then sends a 40-bit frame made of opcode 0x02, the address and the program byte. With auto-advance set, the address then increases by one.
- R8: While a transfer is running, writes to the command, count, address, program-byte and raw-byte registers are ignored.
- R9: The serial interface uses SPI mode 0. The clock idles low, MOSI never changes on a rising clock edge, and MISO is sampled on the rising edge.
- R10: The address reads back through its three byte registers, and advancing it carries across byte boundaries (0x00FFFF becomes 0x010000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| addr_i | input | 5 | register offset |
| wdata_i | input | 8 | write data |
| we_i | input | 1 | write strobe for the addressed byte |
| rdata_o | output | 8 | read data of the addressed register |
| spi_cs_no | output | 1 | chip select, active low |
| spi_sck_o | output | 1 | serial clock |
| spi_mosi_o | output | 1 | serial data to flash |
| spi_miso_i | input | 1 | serial data from flash |

## Verification
The hardest situation to reach from the ports is a second trigger that arrives while a frame is still running, since software would normally wait. The bench creates it by writing a new trigger and a new bit count in the two bus cycles right after a raw trigger. It then checks that only the first frame, with its original length, appears on the pins.

The address carry from 0x00FFFF is reached by loading that value and running a read with auto-advance set. The bench then reads all three address bytes back.

A flash model drives MISO on the falling clock edge. This lets the status and read captures be checked against known bytes.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam logic [4:0] A_CMD    = 5'h00;
  localparam logic [4:0] A_CNT    = 5'h01;
  localparam logic [4:0] A_KEY    = 5'h02;
  localparam logic [4:0] A_STAT   = 5'h03;
  localparam logic [4:0] A_ADDR_L = 5'h06;  // address bytes descend in offset
  localparam logic [4:0] A_RDATA  = 5'h07;
  localparam logic [4:0] A_WDATA  = 5'h08;
  localparam logic [4:0] A_RAW0   = 5'h10;

  localparam int B_RAW  = 0;
  localparam int B_STAT = 1;
  localparam int B_RD   = 2;
  localparam int B_WR   = 3;
  localparam int B_AINC = 7;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PP   = 8'h02;

  typedef enum logic [2:0] {SQ_IDLE, SQ_GO1, SQ_WAIT1, SQ_GO2, SQ_WAIT2} seq_e;
endpackage

// File: rtl/nor_spi_shift.sv
module nor_spi_shift #(
  parameter int MAXB = 48,
  localparam int CW  = $clog2(MAXB + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MAXB-1:0] tx_i,
  input  logic [CW-1:0]   nbits_i,
  output logic            done_o,
  output logic [7:0]      rx_o,
  output logic            cs_no,
  output logic            sck_o,
  output logic            mosi_o,
  input  logic            miso_i
);
  logic            active_q, ph_q, sck_q, done_q;
  logic [CW-1:0]   cnt_q;
  logic [MAXB-1:0] tx_q;
  logic [7:0]      rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; ph_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      cnt_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          if (nbits_i == '0) begin
            done_q <= 1'b1;
          end else begin
            active_q <= 1'b1; tx_q <= tx_i; cnt_q <= nbits_i;
            ph_q <= 1'b0; sck_q <= 1'b0;
          end
        end
      end else if (!ph_q) begin
        ph_q  <= 1'b1;
        sck_q <= 1'b1;
        rx_q  <= {rx_q[6:0], miso_i};
      end else begin
        ph_q  <= 1'b0;
        sck_q <= 1'b0;
        tx_q  <= tx_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign cs_no  = ~active_q;
  assign sck_o  = sck_q;
  assign mosi_o = active_q & tx_q[MAXB-1];

  a_r9_mosi_stable_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));
  a_r8_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cs_no);
endmodule

// File: rtl/nor_addr_ctr.sv
module nor_addr_ctr #(
  parameter int NBYTES = 3,
  localparam int AW    = NBYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBYTES-1:0] ld_i,
  input  logic [7:0]        ld_data_i,
  input  logic              inc_i,
  output logic [AW-1:0]     addr_o
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = inc_i ? addr_q + AW'(1) : addr_q;
    for (int b = 0; b < NBYTES; b++)
      if (ld_i[b]) addr_d[8*b +: 8] = ld_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int         RAW_BYTES  = 6,
  parameter int         ADDR_BYTES = 3,
  parameter logic [7:0] UNLOCK_KEY = 8'h30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  output logic [7:0] rdata_o,
  output logic       spi_cs_no,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);
  localparam int MAXB  = RAW_BYTES * 8;
  localparam int CW    = $clog2(MAXB + 1);
  localparam int AW    = ADDR_BYTES * 8;
  localparam int FULLB = 16 + AW;
  localparam int PADB  = MAXB - FULLB;

  logic [3:0]  trig_q;
  logic        ainc_q;
  logic [7:0]  cnt_q, key_q, stat_q, rdata_q, wdata_q;
  logic [7:0]  raw_q [RAW_BYTES];
  seq_e        seq_q;

  logic            busy, unlocked, reg_we, accept, sh_done, fin, start;
  logic [3:0]      sel;
  logic [7:0]      sh_rx;
  logic [MAXB-1:0] tx_sel;
  logic [CW-1:0]   n_sel;
  logic [AW-1:0]   addr_w;
  logic [ADDR_BYTES-1:0] addr_ld;

  assign busy     = |trig_q;
  assign unlocked = (key_q == UNLOCK_KEY);
  assign reg_we   = we_i && !busy;
  assign accept   = reg_we && addr_i == A_CMD && unlocked && |wdata_i[3:0];
  assign sel      = wdata_i[3:0] & (~wdata_i[3:0] + 4'd1);  // lowest bit wins
  assign start    = (seq_q == SQ_GO1) || (seq_q == SQ_GO2);
  assign fin      = sh_done && ((seq_q == SQ_WAIT2) || (seq_q == SQ_WAIT1 && !trig_q[B_WR]));

  generate
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_ald
      assign addr_ld[b] = reg_we && addr_i == 5'(A_ADDR_L - b);
    end
    for (genvar i = 0; i < RAW_BYTES; i++) begin : g_raw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) raw_q[i] <= '0;
        else if (reg_we && addr_i == 5'(A_RAW0 + i)) raw_q[i] <= wdata_i;
      end
    end
  endgenerate

  always_comb begin
    tx_sel = '0;
    n_sel  = '0;
    if (trig_q[B_RAW]) begin
      for (int i = 0; i < RAW_BYTES; i++) tx_sel[8*i +: 8] = raw_q[i];
      n_sel = (32'(cnt_q) > MAXB) ? CW'(MAXB) : CW'(cnt_q);
    end else if (trig_q[B_STAT]) begin
      tx_sel = MAXB'(OP_RDSR) << (MAXB - 8);
      n_sel  = CW'(16);
    end else if (trig_q[B_RD]) begin
      tx_sel = MAXB'({OP_READ, addr_w, 8'h00}) << PADB;
      n_sel  = CW'(FULLB);
    end else if (trig_q[B_WR]) begin
      if (seq_q == SQ_GO2) begin
        tx_sel = MAXB'({OP_PP, addr_w, wdata_q}) << PADB;
        n_sel  = CW'(FULLB);
      end else begin
        tx_sel = MAXB'(OP_WREN) << (MAXB - 8);
        n_sel  = CW'(8);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0; ainc_q <= 1'b0; cnt_q <= '0; key_q <= '0;
      stat_q <= '0; rdata_q <= '0; wdata_q <= '0; seq_q <= SQ_IDLE;
    end else begin
      if (we_i && addr_i == A_KEY) key_q <= wdata_i;
      if (reg_we && addr_i == A_CNT)   cnt_q   <= wdata_i;
      if (reg_we && addr_i == A_WDATA) wdata_q <= wdata_i;
      if (reg_we && addr_i == A_CMD)   ainc_q  <= wdata_i[B_AINC];
      if (accept) begin
        trig_q <= sel;
        seq_q  <= SQ_GO1;
      end
      case (seq_q)
        SQ_GO1:   seq_q <= SQ_WAIT1;
        SQ_GO2:   seq_q <= SQ_WAIT2;
        SQ_WAIT1: if (sh_done) seq_q <= trig_q[B_WR] ? SQ_GO2 : SQ_IDLE;
        SQ_WAIT2: if (sh_done) seq_q <= SQ_IDLE;
        default: ;
      endcase
      if (fin) begin
        trig_q <= '0;
        if (trig_q[B_STAT]) stat_q  <= sh_rx;
        if (trig_q[B_RD])   rdata_q <= sh_rx;
      end
    end
  end

  nor_addr_ctr #(.NBYTES(ADDR_BYTES)) u_addr (
    .clk_i, .rst_ni,
    .ld_i      (addr_ld),
    .ld_data_i (wdata_i),
    .inc_i     (fin && ainc_q && (trig_q[B_RD] || trig_q[B_WR])),
    .addr_o    (addr_w)
  );

  nor_spi_shift #(.MAXB(MAXB)) u_shift (
    .clk_i, .rst_ni,
    .start_i (start),
    .tx_i    (tx_sel),
    .nbits_i (n_sel),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .cs_no   (spi_cs_no),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .miso_i  (spi_miso_i)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CMD:   rdata_o = {ainc_q, 3'b000, trig_q};
      A_CNT:   rdata_o = cnt_q;
      A_KEY:   rdata_o = {7'b0, unlocked};
      A_STAT:  rdata_o = stat_q;
      A_RDATA: rdata_o = rdata_q;
      A_WDATA: rdata_o = wdata_q;
      default: ;
    endcase
    for (int b = 0; b < ADDR_BYTES; b++)
      if (addr_i == 5'(A_ADDR_L - b)) rdata_o = addr_w[8*b +: 8];
    for (int i = 0; i < RAW_BYTES; i++)
      if (addr_i == 5'(A_RAW0 + i)) rdata_o = raw_q[i];
  end

  a_r4_trig_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trig_q));
  a_r4_r8_trig_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !fin) |=> $stable(trig_q));
  a_r2_locked_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && !busy) |=> !busy);
  a_r9_cs_only_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> busy);
  a_r10_addr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && ainc_q && (trig_q[B_RD] || trig_q[B_WR])) |=> addr_w == $past(addr_w) + AW'(1));
endmodule

// File: tb/nor_cmd_engine_tb.sv
`timescale 1ns/1ps
module nor_cmd_engine_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       we = 1'b0;
  logic       cs_n, sck, mosi, miso = 1'b0;

  int n_chk = 0, n_bad = 0, mode_err = 0;

  always #2.5 clk = ~clk;

  nor_cmd_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi),
    .spi_miso_i(miso)
  );

  // flash model
  logic [63:0] cap = '0;
  logic [7:0]  op = '0, stat_v = '0, rd_v = '0;
  int          nb = 0, nf = 0;
  logic [63:0] fr_bits [16];
  int          fr_len  [16];

  always @(negedge cs_n) begin nb = 0; cap = '0; op = '0; end
  always @(posedge sck) begin
    cap = {cap[62:0], mosi};
    nb++;
    if (nb == 8) op = cap[7:0];
  end
  always @(negedge sck) begin
    if (op == 8'h05 && nb >= 8 && nb < 16)       miso <= stat_v[15-nb];
    else if (op == 8'h03 && nb >= 32 && nb < 40) miso <= rd_v[39-nb];
    else                                          miso <= 1'b0;
  end
  always @(posedge cs_n) begin
    if (nb != 0 && nf < 16) begin
      fr_bits[nf] = cap; fr_len[nf] = nb; nf++; nb = 0;
    end
  end

  logic prev_sck = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && sck) mode_err++;
      if (sck && !prev_sck && mosi !== prev_mosi) mode_err++;
    end
    prev_sck = sck; prev_mosi = mosi;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(5'h00, v);
      if (v[3:0] == 4'h0) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(5'h00, v); check("R1 cmd", v, 8'h00);
    rd(5'h02, v); check("R1 key", v, 8'h00);
    check("R1 cs", cs_n, 1'b1);
    check("R1 sck", sck, 1'b0);
  endtask

  task automatic t_locked();
    logic [7:0] v; int f0 = nf;
    wr(5'h00, 8'h01);
    repeat (4) @(negedge clk);
    rd(5'h00, v); check("R2 cmd", v, 8'h00);
    check("R2 frames", nf, f0);
    wr(5'h02, 8'h30);
    rd(5'h02, v); check("R2 unlock", v, 8'h01);
  endtask

  task automatic t_raw_wren();
    logic [7:0] v; int f0 = nf;
    wr(5'h15, 8'h06); wr(5'h01, 8'd8); wr(5'h00, 8'h01);
    rd(5'h00, v); check("R4 busy", v, 8'h01);
    wait_idle();
    check("R3 wren len", fr_len[f0], 8);
    check("R3 wren bits", fr_bits[f0][7:0], 8'h06);
  endtask

  task automatic t_raw_erase();
    int f0 = nf;
    wr(5'h15, 8'h20); wr(5'h14, 8'h12); wr(5'h13, 8'h34); wr(5'h12, 8'h56);
    wr(5'h01, 8'd32); wr(5'h00, 8'h01);
    wait_idle();
    check("R3 erase len", fr_len[f0], 32);
    check("R3 erase bits", fr_bits[f0][31:0], 32'h20123456);
  endtask

  task automatic t_raw_clip();
    int f0 = nf;
    for (int i = 0; i < 6; i++) wr(5'(5'h10 + i), 8'hA0 + 8'(i));
    wr(5'h01, 8'd60); wr(5'h00, 8'h01);
    wait_idle();
    check("R3 clip len", fr_len[f0], 48);
    check("R3 clip bits", fr_bits[f0][47:0], 48'hA5A4A3A2A1A0);
  endtask

  task automatic t_raw_zero();
    logic [7:0] v; int f0 = nf;
    wr(5'h01, 8'd0); wr(5'h00, 8'h01);
    repeat (4) @(negedge clk);
    rd(5'h00, v); check("R3 zero done", v, 8'h00);
    check("R3 zero no cs", nf, f0);
  endtask

  task automatic t_busy();
    logic [7:0] v; int f0 = nf;
    wr(5'h15, 8'h06); wr(5'h01, 8'd32); wr(5'h00, 8'h01);
    wr(5'h00, 8'h02); wr(5'h01, 8'd8); wr(5'h15, 8'h99);
    rd(5'h00, v); check("R8 cmd held", v, 8'h01);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R8 one frame", nf, f0 + 1);
    check("R8 len kept", fr_len[f0], 32);
    rd(5'h01, v); check("R8 cnt kept", v, 8'd32);
    rd(5'h15, v); check("R8 raw kept", v, 8'h06);
  endtask

  task automatic t_status();
    logic [7:0] v; int f0 = nf;
    stat_v = 8'hA5;
    wr(5'h00, 8'h02);
    wait_idle();
    rd(5'h03, v); check("R5 status", v, 8'hA5);
    check("R5 len", fr_len[f0], 16);
    check("R5 opcode", fr_bits[f0][15:8], 8'h05);
  endtask

  task automatic t_read();
    logic [7:0] v; int f0 = nf;
    rd_v = 8'h3C;
    wr(5'h04, 8'h00); wr(5'h05, 8'hFF); wr(5'h06, 8'hFF);
    wr(5'h00, 8'h84);
    wait_idle();
    rd(5'h07, v); check("R6 data", v, 8'h3C);
    check("R6 len", fr_len[f0], 40);
    check("R6 hdr", fr_bits[f0][39:8], 32'h0300FFFF);
    rd(5'h04, v); check("R10 addr hi", v, 8'h01);
    rd(5'h05, v); check("R10 addr mid", v, 8'h00);
    rd(5'h06, v); check("R10 addr lo", v, 8'h00);
    rd_v = 8'hC3;
    wr(5'h00, 8'h04);
    wait_idle();
    rd(5'h07, v); check("R6 data2", v, 8'hC3);
    rd(5'h06, v); check("R6 no advance", v, 8'h00);
  endtask

  task automatic t_write();
    logic [7:0] v; int f0 = nf;
    wr(5'h04, 8'h00); wr(5'h05, 8'h01); wr(5'h06, 8'h00);
    wr(5'h08, 8'h5A); wr(5'h00, 8'h88);
    wait_idle();
    check("R7 frames", nf, f0 + 2);
    check("R7 wren len", fr_len[f0], 8);
    check("R7 wren", fr_bits[f0][7:0], 8'h06);
    check("R7 pp len", fr_len[f0+1], 40);
    check("R7 pp", fr_bits[f0+1][39:0], 40'h020001005A);
    rd(5'h06, v); check("R7 advance", v, 8'h01);
    rd(5'h00, v); check("R4 ainc kept", v, 8'h80);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_raw_wren();
    t_raw_erase();
    t_raw_clip();
    t_raw_zero();
    t_busy();
    t_status();
    t_read();
    t_write();
    check("R9 mode0", mode_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule